// File: doc/BRIEF.md
# Eight-Pin Register-Mapped GPIO with Address-Masked Data Port

This block is a general-purpose I/O peripheral on a plain memory-mapped bus that carries one byte of data. Each pin can be set up as an input or as an output. A data window spans the lower part of the address space. The address bits of any access to that window choose which pins it sees. A write changes only the chosen output pins, and a read returns zero for pins that were not chosen. Software can therefore update or sample single pins without a read-modify-write sequence.

Each pin also has interrupt detection, set up per pin. The sense can be level or edge. The polarity can be high/rising or low/falling, and a separate setting catches both edges. Software can read the raw status and the status after the enable mask. Edge events are latched, and a write-one-to-clear register releases them. All masked bits are ORed into a single interrupt line. Pad inputs pass through an internal synchronizer before anything else uses them.

Top module: `mgpio`

## Requirements
- R1: After reset every configuration register, the output latch and all latched events are zero, so pin_oe, pin_out and irq_out are all low.
- R2: A write to byte address 0x000–0x3FC updates output-latch bit n only when address bit n+2 is 1 and pin n is an output; the other latch bits keep their values.
- R3: A read from byte address 0x000–0x3FC returns 0 in bit n when address bit n+2 is 0. Otherwise bit n is the output latch bit for an output pin, or the synchronized pad value for an input pin.
- R4: The direction register at 0x400 reads back the value written to it, and bit n = 1 drives pin_oe[n] high (output) one cycle after the write.
- R5: The sense (0x404), both-edge (0x408), polarity (0x40C) and enable (0x410) registers read back as written. A read of the clear register (0x41C) or of any unmapped address returns 0.
- R6: A pad change applied before clock edge k appears in data reads and in level status after edge k+1.
- R7: A pin with sense bit 1 is level-sensed. Its raw status equals the synchronized pad value when its polarity bit is 1 and the inverse when it is 0. Writes to the clear register do not affect it.
- R8: A pin with sense bit 0 and both-edge bit 0 latches a raw status bit on a rising synchronized edge (polarity 1) or a falling one (polarity 0). The bit stays set until it is cleared.
- R9: An edge-sensed pin with its both-edge bit set latches on either edge, whatever its polarity bit says.
- R10: Raw status reads at 0x414, and masked status at 0x418 reads as raw status AND the enable register.
- R11: Writing 1 to bit n of 0x41C clears pin n's latched edge status, and writing 0 leaves it. When a new edge is detected in the same cycle as the clear, the bit stays set.
- R12: irq_out is high exactly when at least one masked status bit is 1.
- R13: A data write that targets an input pin leaves its latch bit unchanged, so a later switch of that pin to output drives the earlier latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address (byte address bits 11:2) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not reading |
| pin_in | input | 8 | Asynchronous pad inputs |
| pin_out | output | 8 | Output latch value per pin |
| pin_oe | output | 8 | Output enable per pin (direction register) |
| irq_out | output | 1 | Combined interrupt |

## Verification
The collision of interest is a clear-register write landing on the same clock edge at which a new edge event on that pin is latched. The bench changes a pad, waits the two synchronizer cycles, and issues the clear exactly on the latching edge. Its behavioural model expects the status bit to remain set, and a second clear with no event pending must then drop it. A data-port write is also aimed at pins that are still inputs before their direction flips, and the driven value is then judged against the older latch contents.

// File: rtl/mgp_pkg.sv
package mgp_pkg;

   // Control page register index, taken from byte address bits [4:2].
   typedef enum logic [2:0] {
      SEL_DIR    = 3'd0,
      SEL_SENSE  = 3'd1,
      SEL_BOTH   = 3'd2,
      SEL_POL    = 3'd3,
      SEL_EN     = 3'd4,
      SEL_RAW    = 3'd5,
      SEL_MASKED = 3'd6,
      SEL_CLEAR  = 3'd7
   } ctl_sel_e;

   // Decoded view of one bus access.
   typedef struct packed {
      logic     data_hit;
      logic     ctl_hit;
      ctl_sel_e sel;
   } acc_dec_t;

endpackage

// File: rtl/mgp_sync.sv
module mgp_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mgp_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("mgp_sync: W must be positive");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/mgp_regs.sv
module mgp_regs
   import mgp_pkg::*;
#(
   parameter int NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  ctl_sel_e         sel,
   input  logic             data_wr,
   input  logic [NPINS-1:0] pin_mask,
   input  logic [NPINS-1:0] wdata,
   output logic [NPINS-1:0] dir_q,
   output logic [NPINS-1:0] sense_q,
   output logic [NPINS-1:0] both_q,
   output logic [NPINS-1:0] pol_q,
   output logic [NPINS-1:0] en_q,
   output logic [NPINS-1:0] out_q
);

   // Latch bits that a data write may touch: addressed and currently output.
   logic [NPINS-1:0] upd;
   assign upd = pin_mask & dir_q & {NPINS{data_wr}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         sense_q <= '0;
         both_q  <= '0;
         pol_q   <= '0;
         en_q    <= '0;
      end else if (ctl_wr) begin
         case (sel)
            SEL_DIR:   dir_q   <= wdata;
            SEL_SENSE: sense_q <= wdata;
            SEL_BOTH:  both_q  <= wdata;
            SEL_POL:   pol_q   <= wdata;
            SEL_EN:    en_q    <= wdata;
            default:   ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= '0;
      else        out_q <= (out_q & ~upd) | (wdata & upd);
   end

endmodule

// File: rtl/mgp_irq.sv
module mgp_irq #(
   parameter int NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] sync_in,
   input  logic [NPINS-1:0] sense,
   input  logic [NPINS-1:0] both,
   input  logic [NPINS-1:0] pol,
   input  logic [NPINS-1:0] clr,
   output logic [NPINS-1:0] raw
);

   logic [NPINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_in;
   end

   generate
      for (genvar n = 0; n < NPINS; n++) begin : g_pin
         logic ev;
         logic lat_q;

         always_comb begin
            if (both[n])     ev = sync_in[n] ^ prev_q[n];
            else if (pol[n]) ev = sync_in[n] & ~prev_q[n];
            else             ev = ~sync_in[n] & prev_q[n];
         end

         // A fresh event outranks a clear in the same cycle.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        lat_q <= 1'b0;
            else if (sense[n]) lat_q <= 1'b0;
            else               lat_q <= ev | (lat_q & ~clr[n]);
         end

         assign raw[n] = sense[n] ? (sync_in[n] ~^ pol[n]) : lat_q;
      end
   endgenerate

endmodule

// File: rtl/mgpio.sv
module mgpio
   import mgp_pkg::*;
#(
   parameter int NPINS       = 8,
   parameter int BUS_W       = 8,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:2] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq_out
);

   localparam int MASK_HI = NPINS + 1;
   localparam int PAGE_LO = NPINS + 2;
   localparam int PAGE_W  = ADDR_W - PAGE_LO;
   localparam logic [PAGE_W-1:0] DATA_PAGE = '0;
   localparam logic [PAGE_W-1:0] CTL_PAGE  = PAGE_W'(1);

   generate
      if (NPINS < 4 || NPINS > BUS_W) begin : g_bad_npins
         $error("mgpio: NPINS must lie between 4 and BUS_W");
      end
      if (ADDR_W < NPINS + 3) begin : g_bad_addr
         $error("mgpio: ADDR_W too small for data window and control page");
      end
   endgenerate

   // ---------------- decode ----------------
   acc_dec_t         dec;
   logic [NPINS-1:0] pin_mask;
   logic [NPINS-1:0] wdata_p;
   logic             wr;

   assign pin_mask = bus_addr[MASK_HI:2];
   assign wdata_p  = bus_wdata[NPINS-1:0];
   assign wr       = bus_en && bus_we;

   always_comb begin
      dec.data_hit = bus_en && (bus_addr[ADDR_W-1:PAGE_LO] == DATA_PAGE);
      dec.ctl_hit  = bus_en && (bus_addr[ADDR_W-1:PAGE_LO] == CTL_PAGE)
                     && (bus_addr[MASK_HI:5] == '0);
      dec.sel      = ctl_sel_e'(bus_addr[4:2]);
   end

   // ---------------- state ----------------
   logic [NPINS-1:0] dir_q, sense_q, both_q, pol_q, en_q, out_q;
   logic [NPINS-1:0] sync_q, raw_st, msk_st, clr_bits;

   mgp_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (sync_q)
   );

   mgp_regs #(.NPINS(NPINS)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (wr && dec.ctl_hit),
      .sel      (dec.sel),
      .data_wr  (wr && dec.data_hit),
      .pin_mask (pin_mask),
      .wdata    (wdata_p),
      .dir_q    (dir_q),
      .sense_q  (sense_q),
      .both_q   (both_q),
      .pol_q    (pol_q),
      .en_q     (en_q),
      .out_q    (out_q)
   );

   assign clr_bits = (wr && dec.ctl_hit && dec.sel == SEL_CLEAR) ? wdata_p : '0;

   mgp_irq #(.NPINS(NPINS)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_in (sync_q),
      .sense   (sense_q),
      .both    (both_q),
      .pol     (pol_q),
      .clr     (clr_bits),
      .raw     (raw_st)
   );

   assign msk_st  = raw_st & en_q;
   assign irq_out = |msk_st;
   assign pin_out = out_q;
   assign pin_oe  = dir_q;

   // ---------------- read path ----------------
   logic [NPINS-1:0] rd_p;

   always_comb begin
      rd_p = '0;
      if (bus_en && !bus_we) begin
         if (dec.data_hit) begin
            rd_p = pin_mask & ((dir_q & out_q) | (~dir_q & sync_q));
         end else if (dec.ctl_hit) begin
            case (dec.sel)
               SEL_DIR:    rd_p = dir_q;
               SEL_SENSE:  rd_p = sense_q;
               SEL_BOTH:   rd_p = both_q;
               SEL_POL:    rd_p = pol_q;
               SEL_EN:     rd_p = en_q;
               SEL_RAW:    rd_p = raw_st;
               SEL_MASKED: rd_p = msk_st;
               default:    rd_p = '0;
            endcase
         end
      end
   end

   generate
      if (BUS_W > NPINS) begin : g_pad
         assign bus_rdata = {{(BUS_W-NPINS){1'b0}}, rd_p};
      end else begin : g_nopad
         assign bus_rdata = rd_p;
      end
   endgenerate

endmodule

// File: rtl/mgpio_chk.sv
module mgpio_chk #(
   parameter int NPINS  = 8,
   parameter int BUS_W  = 8,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_we,
   input logic [ADDR_W-1:2] bus_addr,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic [NPINS-1:0]  pin_out,
   input logic [NPINS-1:0]  pin_oe,
   input logic              irq_out,
   input logic [NPINS-1:0]  dir_q,
   input logic [NPINS-1:0]  sense_q,
   input logic [NPINS-1:0]  en_q,
   input logic [NPINS-1:0]  raw_st
);

   localparam int PAGE_LO = NPINS + 2;
   localparam int PAGE_W  = ADDR_W - PAGE_LO;

   logic acc_wr, data_wr, dir_wr;
   assign acc_wr  = bus_en && bus_we;
   assign data_wr = acc_wr && (bus_addr[ADDR_W-1:PAGE_LO] == '0);
   assign dir_wr  = acc_wr && (bus_addr[ADDR_W-1:PAGE_LO] == PAGE_W'(1))
                    && (bus_addr[NPINS+1:2] == '0);

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && !irq_out)); // R1

   AST_DIR_WRITE_DRIVES_OE: assert property (@(posedge clk) disable iff (!rst_n)
      dir_wr |=> (pin_oe == $past(bus_wdata[NPINS-1:0]))); // R4

   AST_EDGE_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_wr |=> (($past(raw_st) & ~$past(sense_q) & ~raw_st) == '0)); // R8

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (en_q != '0)); // R12

   AST_INPUT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && dir_q == '0) |=> $stable(pin_out)); // R13

endmodule

bind mgpio mgpio_chk #(.NPINS(NPINS), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_en    (bus_en),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq_out   (irq_out),
   .dir_q     (dir_q),
   .sense_q   (sense_q),
   .en_q      (en_q),
   .raw_st    (raw_st)
);

// File: tb/tb_mgpio.sv
module tb_mgpio;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_en = 1'b0;
   logic       bus_we = 1'b0;
   logic [11:2] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] pin_in = '0;
   logic [7:0] pin_out, pin_oe;
   logic       irq_out;

   always #5 clk = ~clk;

   mgpio dut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
   );

   // ---------------- behavioural model ----------------
   int         vectors = 0;
   int         fails = 0;
   int         cyc = 0;
   bit         done = 1'b0;
   string      tag = "R1";
   logic [7:0] m_dir = '0, m_sense = '0, m_both = '0, m_pol = '0, m_en = '0;
   logic [7:0] m_out = '0, m_lat = '0;
   logic [7:0] hist[$] = '{8'h00, 8'h00, 8'h00, 8'h00};

   function automatic logic [7:0] m_raw();
      logic [7:0] r;
      for (int n = 0; n < 8; n++) begin
         if (m_sense[n]) r[n] = m_pol[n] ? hist[1][n] : !hist[1][n];
         else            r[n] = m_lat[n];
      end
      return r;
   endfunction

   function automatic logic [7:0] m_read();
      int unsigned a;
      a = {bus_addr, 2'b00};
      if (!bus_en || bus_we) return 8'h00;
      if (a < 12'h400) begin
         logic [7:0] v;
         for (int n = 0; n < 8; n++)
            v[n] = a[n+2] ? (m_dir[n] ? m_out[n] : hist[1][n]) : 1'b0;
         return v;
      end
      case (a)
         12'h400: return m_dir;
         12'h404: return m_sense;
         12'h408: return m_both;
         12'h40C: return m_pol;
         12'h410: return m_en;
         12'h414: return m_raw();
         12'h418: return m_raw() & m_en;
         default: return 8'h00;
      endcase
   endfunction

   task automatic model_edge();
      int unsigned a;
      logic [7:0]  s, p;
      a = {bus_addr, 2'b00};
      s = hist[1];
      p = hist[2];
      for (int n = 0; n < 8; n++) begin
         bit ev, cl;
         if (m_both[n])     ev = s[n] != p[n];
         else if (m_pol[n]) ev = s[n] && !p[n];
         else               ev = !s[n] && p[n];
         cl = bus_en && bus_we && a == 12'h41C && bus_wdata[n];
         if (m_sense[n]) m_lat[n] = 1'b0;
         else            m_lat[n] = ev || (m_lat[n] && !cl);
      end
      if (bus_en && bus_we) begin
         if (a < 12'h400) begin
            for (int n = 0; n < 8; n++)
               if (a[n+2] && m_dir[n]) m_out[n] = bus_wdata[n];
         end else begin
            case (a)
               12'h400: m_dir   = bus_wdata;
               12'h404: m_sense = bus_wdata;
               12'h408: m_both  = bus_wdata;
               12'h40C: m_pol   = bus_wdata;
               12'h410: m_en    = bus_wdata;
               default: ;
            endcase
         end
      end
      hist.push_front(pin_in);
      void'(hist.pop_back());
   endtask

   task automatic check8(string what, logic [7:0] got, logic [7:0] exp);
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h (t=%0t)", tag, what, got, exp, $time);
      end
   endtask

   task automatic compare();
      vectors++;
      check8("bus_rdata", bus_rdata, m_read());
      check8("pin_out", pin_out, m_out);
      check8("pin_oe", pin_oe, m_dir);
      check8("irq_out", {7'd0, irq_out}, {7'd0, |(m_raw() & m_en)});
   endtask

   task automatic tick();
      #1;
      compare();
      @(posedge clk);
      if (rst_n) model_edge();
      @(negedge clk);
   endtask

   task automatic idle(int n);
      bus_en = 1'b0; bus_we = 1'b0;
      repeat (n) tick();
   endtask

   task automatic wr(logic [11:0] a, logic [7:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a[11:2]; bus_wdata = d;
      tick();
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(logic [11:0] a);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a[11:2];
      tick();
      bus_en = 1'b0;
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 50000) begin
         fails++;
         $display("FAIL R1 watchdog: cycles %0d expected fewer than 50000", cyc);
         report();
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      @(negedge clk);
      tag = "R1";
      rd(12'h400); rd(12'h3FC); idle(2);
      rst_n = 1'b1;
      rd(12'h400); rd(12'h414); rd(12'h410);

      tag = "R4";
      wr(12'h400, 8'hF0); rd(12'h400); idle(1);

      tag = "R2";
      wr(12'h0F0, 8'hFF);                 // mask 0x3C: pins 4,5 only
      rd(12'h3FC); rd(12'h0C0);
      wr(12'h3FC, 8'h5A); rd(12'h3FC);

      tag = "R13";
      wr(12'h03C, 8'h0F);                 // pins 0-3 are inputs: ignored
      wr(12'h400, 8'hFF);
      rd(12'h3FC); idle(1);
      wr(12'h03C, 8'h0F); rd(12'h3FC);    // now outputs: takes effect

      tag = "R3";
      wr(12'h400, 8'h0F);
      pin_in = 8'hA5; idle(3);
      rd(12'h3C0); rd(12'h03C); rd(12'h3FC); rd(12'h000);

      tag = "R6";
      pin_in = 8'h5A;
      rd(12'h3C0); rd(12'h3C0); rd(12'h3C0); rd(12'h3C0);

      tag = "R5";
      wr(12'h404, 8'h11); wr(12'h408, 8'h22); wr(12'h40C, 8'h44); wr(12'h410, 8'h88);
      rd(12'h404); rd(12'h408); rd(12'h40C); rd(12'h410);
      rd(12'h41C); rd(12'h420); rd(12'h800); rd(12'hC00);

      tag = "R7";
      wr(12'h400, 8'h00); wr(12'h408, 8'h00);
      wr(12'h404, 8'h03); wr(12'h40C, 8'h01); wr(12'h410, 8'hFF);
      pin_in = 8'h00; idle(3); rd(12'h414);
      pin_in = 8'h01; rd(12'h414); rd(12'h414); rd(12'h414);
      wr(12'h41C, 8'h03); rd(12'h414);
      pin_in = 8'h02; idle(3); rd(12'h414); rd(12'h418);

      tag = "R8";
      wr(12'h404, 8'h00); wr(12'h40C, 8'h04);
      pin_in = 8'h08; idle(3);
      wr(12'h41C, 8'hFF); rd(12'h414);
      pin_in = 8'h04; idle(3); rd(12'h414);   // pin2 rise, pin3 fall
      pin_in = 8'h08; idle(3); rd(12'h414);   // pin2 fall, pin3 rise
      wr(12'h41C, 8'h04); rd(12'h414);
      wr(12'h41C, 8'h08); rd(12'h414);

      tag = "R9";
      wr(12'h408, 8'h10); wr(12'h40C, 8'h00);
      wr(12'h41C, 8'hFF);
      pin_in = 8'h10; idle(3); rd(12'h414);
      wr(12'h41C, 8'h10); rd(12'h414);
      pin_in = 8'h00; idle(3); rd(12'h414);

      tag = "R10";
      wr(12'h410, 8'h04); rd(12'h418); rd(12'h414);
      wr(12'h410, 8'h10); rd(12'h418);

      tag = "R11";
      wr(12'h41C, 8'hFF); rd(12'h414);
      pin_in = 8'h10; idle(2);                 // event now pending latch
      wr(12'h41C, 8'h10);                      // clear on the latching edge
      rd(12'h414);
      wr(12'h41C, 8'h00); rd(12'h414);         // zero write: no effect
      wr(12'h41C, 8'h10); rd(12'h414);

      tag = "R12";
      wr(12'h410, 8'h00);
      pin_in = 8'h00; idle(3); rd(12'h414);
      wr(12'h410, 8'hFF); idle(2);
      wr(12'h41C, 8'hFF); idle(2);

      tag = "R1";
      rst_n = 1'b0;
      m_dir = '0; m_sense = '0; m_both = '0; m_pol = '0; m_en = '0;
      m_out = '0; m_lat = '0;
      hist = '{8'h00, 8'h00, 8'h00, 8'h00};
      pin_in = 8'h00;
      idle(2); rd(12'h400);
      rst_n = 1'b1;
      rd(12'h414); idle(2);

      report();
   end

endmodule